// File: doc/BRIEF.md
# Glitch-Free Clock Output Enable Bank

This block sits between a chip's clock source and a row of differential clock output pairs. Each pair is switched on or off by one bit of a 16-bit configuration value. The value arrives as two 8-bit bytes. A switched-off pair releases both of its wires to high impedance. A separate feedback pair carries the same clock at all times and never responds to the configuration. A test control selects a reference clock in place of the internal clock. That selection applies to every output, including the feedback pair.

The configuration bytes may change at any moment and with no relation to the output clock. Each enable bit first passes through a synchronizer in the selected clock's domain. It is then captured on that clock's falling edge. An output therefore starts or stops only while its clock is low, and every high pulse it produces is a whole half period. During reset every pair is driven. Reset holds the enable state at all ones, so the outputs stay active until a new configuration has crossed the synchronizer.

Top module: `oeb_bank`

## Requirements
- R1: Pair i (0 to PAIR_COUNT-1) is enabled by bit i of the combined value {cfg_hi, cfg_lo}. Pairs 0..7 take cfg_lo[i] and pairs 8..15 take cfg_hi[i-8]. A 1 enables the pair and a 0 disables it.
- R2: A disabled pair drives neither wire. Both out_t[i] and out_c[i] are high impedance.
- R3: An enabled pair drives out_t[i] equal to the selected clock, and out_c[i] equal to its inverse.
- R4: The feedback pair is driven at all times, whatever the configuration. fb_t equals the selected clock and fb_c is its inverse.
- R5: A pair changes between driven and high impedance only while the selected clock is low. Each phase an output shows is a whole half period. A pair never moves directly between driven-high and high impedance.
- R6: A configuration change is taken into the synchronizer at the next rising edge of the selected clock. It reaches the pair at the falling edge that follows SYNC_STAGES rising edges, so it is first visible in the high phase after SYNC_STAGES+1 rising edges.
- R7: With bypass = 1, all outputs follow ref_clk. With bypass = 0, they follow clk_int.
- R8: While rst_n is low, and after its release until a new value has been synchronized, every pair is enabled whatever the configuration bytes hold.
- R9: Configuration bits at positions PAIR_COUNT and above have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_int | input | 1 | Internal clock used in normal operation |
| ref_clk | input | 1 | Reference clock used in test bypass |
| bypass | input | 1 | 1 selects ref_clk for all outputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lo | input | 8 | Enable bits for pairs 0 to 7 |
| cfg_hi | input | 8 | Enable bits for pairs 8 to 15 |
| out_t | output | PAIR_COUNT | True wire of each gated pair, high impedance when disabled |
| out_c | output | PAIR_COUNT | Complement wire of each gated pair, high impedance when disabled |
| fb_t | output | 1 | True wire of the ungated feedback pair |
| fb_c | output | 1 | Complement wire of the ungated feedback pair |

## Verification
Two events can fall on the same cycle: an enable change reaching a pair, and a switch of the selected clock source through bypass. Both move the falling edge at which the pair's state updates. The bench provokes this by changing the configuration bytes and bypass at the same instant. After settling, it judges the pair states and the measured clock period against the new configuration and the new source. Throughout the run, a phase monitor watches every pair for a state that changes during a phase, or a high phase that appears out of the high-impedance state.

// File: rtl/oeb_pkg.sv
package oeb_pkg;

   localparam int BYTE_W    = 8;
   localparam int CFG_BYTES = 2;
   localparam int CFG_W     = BYTE_W * CFG_BYTES;
   localparam int MAX_PAIRS = CFG_W;
   localparam int MIN_SYNC  = 2;

   typedef logic [BYTE_W-1:0] cfg_byte_t;
   typedef logic [CFG_W-1:0]  cfg_word_t;

   typedef enum logic {
      SRC_INTERNAL  = 1'b0,
      SRC_REFERENCE = 1'b1
   } clk_src_e;

   // The low byte serves pairs 0..7 and the high byte serves pairs 8..15.
   function automatic cfg_word_t join_cfg(input cfg_byte_t lo, input cfg_byte_t hi);
      return {hi, lo};
   endfunction

endpackage

// File: rtl/oeb_clk_sel.sv
module oeb_clk_sel #(
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic            clk_int,
   input  logic            ref_clk,
   input  oeb_pkg::clk_src_e src,
   output logic            clk_sel
);
   generate
      if (BYPASS_EN) begin : g_mux
         always_comb begin
            clk_sel = (src == oeb_pkg::SRC_REFERENCE) ? ref_clk : clk_int;
         end
      end else begin : g_fixed
         logic unused_sel;
         assign unused_sel = ref_clk ^ src;
         assign clk_sel    = clk_int;
      end
   endgenerate
endmodule

// File: rtl/oeb_en_sync.sv
module oeb_en_sync #(
   parameter int WIDTH  = 10,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int LAST = STAGES - 1;

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '1;
      else        stg[0] <= d;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '1;
            else        stg[s] <= stg[s-1];
         end
      end
   endgenerate

   assign q = stg[LAST];
endmodule

// File: rtl/oeb_gate_cell.sv
module oeb_gate_cell #(
   parameter bit GATED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_req,
   output wire  pad_t,
   output wire  pad_c
);
   generate
      if (GATED) begin : g_gated
         logic en_q;
         // Capture on the falling edge: the clock is low when the state moves.
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) en_q <= 1'b1;
            else        en_q <= en_req;
         end
         assign pad_t = en_q ? clk  : 1'bz;
         assign pad_c = en_q ? ~clk : 1'bz;
      end else begin : g_always_on
         logic unused_cell;
         assign unused_cell = en_req ^ rst_n;
         assign pad_t = clk;
         assign pad_c = ~clk;
      end
   endgenerate
endmodule

// File: rtl/oeb_bank.sv
module oeb_bank #(
   parameter int PAIR_COUNT  = 10,
   parameter int SYNC_STAGES = 2,
   parameter bit BYPASS_EN   = 1'b1
) (
   input  logic                  clk_int,
   input  logic                  ref_clk,
   input  logic                  bypass,
   input  logic                  rst_n,
   input  logic [7:0]            cfg_lo,
   input  logic [7:0]            cfg_hi,
   output wire  [PAIR_COUNT-1:0] out_t,
   output wire  [PAIR_COUNT-1:0] out_c,
   output wire                   fb_t,
   output wire                   fb_c
);
   import oeb_pkg::*;

   localparam int SPARE_BITS = CFG_W - PAIR_COUNT;

   generate
      if (PAIR_COUNT < 1 || PAIR_COUNT > MAX_PAIRS) begin : g_bad_pairs
         $error("oeb_bank: PAIR_COUNT must lie in 1..%0d", MAX_PAIRS);
      end
      if (SYNC_STAGES < MIN_SYNC) begin : g_bad_sync
         $error("oeb_bank: SYNC_STAGES must be at least %0d", MIN_SYNC);
      end
   endgenerate

   clk_src_e             src;
   logic                 clk_sel;
   cfg_word_t            cfg_all;
   logic [PAIR_COUNT-1:0] en_async;
   logic [PAIR_COUNT-1:0] en_sync;

   assign src     = bypass ? SRC_REFERENCE : SRC_INTERNAL;
   assign cfg_all = join_cfg(cfg_lo, cfg_hi);
   assign en_async = cfg_all[PAIR_COUNT-1:0];

   generate
      if (SPARE_BITS > 0) begin : g_spare
         logic unused_spare;
         assign unused_spare = ^cfg_all[CFG_W-1:PAIR_COUNT];
      end
   endgenerate

   oeb_clk_sel #(.BYPASS_EN(BYPASS_EN)) u_sel (
      .clk_int (clk_int),
      .ref_clk (ref_clk),
      .src     (src),
      .clk_sel (clk_sel)
   );

   oeb_en_sync #(.WIDTH(PAIR_COUNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk_sel),
      .rst_n (rst_n),
      .d     (en_async),
      .q     (en_sync)
   );

   generate
      for (genvar i = 0; i < PAIR_COUNT; i++) begin : g_pair
         oeb_gate_cell #(.GATED(1'b1)) u_cell (
            .clk    (clk_sel),
            .rst_n  (rst_n),
            .en_req (en_sync[i]),
            .pad_t  (out_t[i]),
            .pad_c  (out_c[i])
         );
      end
   endgenerate

   oeb_gate_cell #(.GATED(1'b0)) u_fb (
      .clk    (clk_sel),
      .rst_n  (rst_n),
      .en_req (1'b1),
      .pad_t  (fb_t),
      .pad_c  (fb_c)
   );
endmodule

// File: rtl/oeb_bank_chk.sv
module oeb_bank_chk #(
   parameter int PAIR_COUNT = 10
) (
   input logic                  clk_int,
   input logic                  ref_clk,
   input logic                  bypass,
   input logic                  rst_n,
   input logic [7:0]            cfg_lo,
   input logic [7:0]            cfg_hi,
   input logic [PAIR_COUNT-1:0] out_t,
   input logic [PAIR_COUNT-1:0] out_c,
   input logic                  fb_t,
   input logic                  fb_c
);
   logic [PAIR_COUNT-1:0] drv;
   logic                  unused_chk;

   assign unused_chk = ^{cfg_lo, cfg_hi};

   // A driven pair is always complementary; a released pair is not.
   always_comb begin
      for (int i = 0; i < PAIR_COUNT; i++) drv[i] = (out_t[i] !== out_c[i]);
   end

   always @(drv) begin
      if (rst_n === 1'b1) begin
         AST_NO_RUNT: assert (fb_t === 1'b0) else $error("pair state moved while clock high"); // R5
      end
   end

   always @(posedge clk_int) begin
      if (rst_n === 1'b0) begin
         AST_RESET_ALL_ON: assert (&drv) else $error("pair released during reset"); // R8
      end
   end

   AST_FB_DRIVEN: assert property (@(negedge clk_int) disable iff (!rst_n)
      fb_t !== fb_c) else $error("feedback pair not complementary"); // R4

   AST_SRC_INTERNAL: assert property (@(negedge clk_int) disable iff (!rst_n)
      (!bypass && $stable(bypass)) |-> fb_t === 1'b1) else $error("feedback not on clk_int"); // R7

   AST_SRC_REFERENCE: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (bypass && $stable(bypass)) |-> fb_t === 1'b0) else $error("feedback not on ref_clk"); // R7

   generate
      for (genvar i = 0; i < PAIR_COUNT; i++) begin : g_pair_chk
         AST_PAIR_FOLLOWS: assert property (@(negedge clk_int) disable iff (!rst_n)
            (!bypass && $stable(bypass) && drv[i]) |-> out_t[i] === 1'b1)
            else $error("enabled pair not following clock"); // R3
      end
   endgenerate
endmodule

bind oeb_bank oeb_bank_chk #(.PAIR_COUNT(PAIR_COUNT)) u_chk (.*);

// File: tb/oeb_bank_test.sv
module oeb_bank_test;
   localparam int P    = 10;
   localparam int SYNC = 2;
   localparam logic [1:0] C_HI  = 2'b10;
   localparam logic [1:0] C_LO  = 2'b01;
   localparam logic [1:0] C_OFF = 2'b11;

   logic       clk_int = 1'b0;
   logic       ref_clk = 1'b0;
   logic       bypass;
   logic       rst_n;
   logic [7:0] cfg_lo, cfg_hi;
   wire  [P-1:0] out_t, out_c;
   wire        fb_t, fb_c;

   int n_chk  = 0;
   int n_fail = 0;
   int runt_events = 0;
   bit mon_on = 1'b0;
   bit done = 1'b0;

   always #5 clk_int = ~clk_int;
   always #7 ref_clk = ~ref_clk;

   // Released wires settle high, so an idle pair reads as 11.
   for (genvar i = 0; i < P; i++) begin : g_pull
      pullup (out_t[i]);
      pullup (out_c[i]);
   end

   oeb_bank #(.PAIR_COUNT(P), .SYNC_STAGES(SYNC)) uut (
      .clk_int (clk_int), .ref_clk (ref_clk), .bypass (bypass), .rst_n (rst_n),
      .cfg_lo (cfg_lo), .cfg_hi (cfg_hi),
      .out_t (out_t), .out_c (out_c), .fb_t (fb_t), .fb_c (fb_c)
   );

   function automatic logic [P-1:0] exp_mask(input logic [7:0] lo, input logic [7:0] hi);
      logic [15:0] w;
      w = {hi, lo};
      return w[P-1:0];
   endfunction

   task automatic check_phase(input logic [P-1:0] en, input bit lvl, input string tag);
      bit bad = 1'b0;
      n_chk++;
      for (int i = 0; i < P; i++) begin
         logic [1:0] e, g;
         e = en[i] ? (lvl ? C_HI : C_LO) : C_OFF;
         g = {out_t[i], out_c[i]};
         if (g !== e) begin
            bad = 1'b1;
            $display("FAIL %s pair %0d: got %b expected %b", tag, i, g, e);
         end
      end
      if ({fb_t, fb_c} !== {lvl, ~lvl}) begin
         bad = 1'b1;
         $display("FAIL R4 %s feedback: got %b expected %b", tag, {fb_t, fb_c}, {lvl, ~lvl});
      end
      if (bad) n_fail++;
   endtask

   task automatic check_both(input logic [P-1:0] en, input string tag);
      @(posedge fb_t); #2 check_phase(en, 1'b1, tag);
      @(negedge fb_t); #2 check_phase(en, 1'b0, tag);
   endtask

   task automatic check_period(input int exp, input string tag);
      time t0, t1;
      @(posedge fb_t); t0 = $time;
      @(posedge fb_t); t1 = $time;
      n_chk++;
      if (t1 - t0 != exp) begin
         n_fail++;
         $display("FAIL %s period: got %0t expected %0d", tag, t1 - t0, exp);
      end
   endtask

   // Phase monitor: a pair keeps one state for a whole phase, and a high
   // phase only follows a driven low phase.
   logic [1:0] prev_code [P];
   bit primed = 1'b0;
   always @(fb_t) begin
      if (mon_on) begin
         bit lvl;
         logic [1:0] c1 [P];
         lvl = fb_t;
         #1;
         for (int i = 0; i < P; i++) c1[i] = {out_t[i], out_c[i]};
         #3;
         for (int i = 0; i < P; i++) begin
            if ({out_t[i], out_c[i]} !== c1[i]) runt_events++;
            if (primed) begin
               if (lvl && c1[i] !== ((prev_code[i] == C_LO) ? C_HI : C_OFF)) runt_events++;
               if (!lvl && c1[i] !== C_LO && c1[i] !== C_OFF) runt_events++;
            end
            prev_code[i] = c1[i];
         end
         primed = 1'b1;
      end else begin
         primed = 1'b0;
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] lo, hi;
      void'($urandom(32'h5eed_c10c));
      cfg_lo = '1; cfg_hi = '1; bypass = 1'b0; rst_n = 1'b1;
      #2 rst_n = 1'b0;
      cfg_lo = 8'h00; cfg_hi = 8'h00;
      repeat (3) @(posedge clk_int);
      #2 check_phase('1, 1'b1, "R8 in reset");
      @(negedge clk_int); #1 rst_n = 1'b1;
      @(posedge clk_int); #2 check_phase('1, 1'b1, "R8 after release");
      repeat (SYNC + 2) @(posedge clk_int);
      check_both('0, "R2 all off");
      mon_on = 1'b1;

      // R6: exact arrival cycle of one enable.
      @(posedge clk_int); #1 cfg_lo = 8'h01;
      repeat (SYNC) @(posedge clk_int);
      #2 check_phase('0, 1'b1, "R6 before arrival");
      @(posedge clk_int); #2 check_phase(10'h001, 1'b1, "R6 on arrival");

      // R1: one pair in each byte.
      cfg_lo = 8'h00; cfg_hi = 8'h02;
      repeat (SYNC + 3) @(posedge clk_int);
      check_both(10'h200, "R1 high byte pair 9");

      // R9: bits beyond the last pair change nothing.
      cfg_lo = 8'hA5; cfg_hi = 8'h01;
      repeat (SYNC + 3) @(posedge clk_int);
      check_both(10'h1A5, "R9 spare bits clear");
      cfg_hi = 8'hFD;
      repeat (SYNC + 3) @(posedge clk_int);
      check_both(10'h1A5, "R9 spare bits set");

      // R1 R2 R3 R5: random configurations changed at random offsets.
      for (int k = 0; k < 40; k++) begin
         lo = 8'($urandom); hi = 8'($urandom);
         #($urandom_range(0, 9));
         cfg_lo = lo; cfg_hi = hi;
         repeat (SYNC + 3) @(posedge fb_t);
         check_both(exp_mask(lo, hi), "R1 R2 R3 random");
      end
      check_period(10, "R7 internal");

      // R7: bypass to the reference clock.
      mon_on = 1'b0;
      bypass = 1'b1;
      repeat (3) @(posedge ref_clk);
      mon_on = 1'b1;
      check_period(14, "R7 bypass");
      for (int k = 0; k < 10; k++) begin
         lo = 8'($urandom); hi = 8'($urandom);
         #($urandom_range(0, 13));
         cfg_lo = lo; cfg_hi = hi;
         repeat (SYNC + 3) @(posedge fb_t);
         check_both(exp_mask(lo, hi), "R7 R1 bypass random");
      end

      // Enable change and source switch at the same instant.
      mon_on = 1'b0;
      @(posedge ref_clk); #3;
      bypass = 1'b0; cfg_lo = 8'h3C; cfg_hi = 8'h02;
      repeat (SYNC + 3) @(posedge clk_int);
      mon_on = 1'b1;
      check_both(10'h23C, "R6 R7 simultaneous");
      check_period(10, "R7 back to internal");
      repeat (4) @(posedge clk_int);

      n_chk++;
      if (runt_events != 0) begin
         n_fail++;
         $display("FAIL R5 phase monitor: got %0d events expected 0", runt_events);
      end
      mon_on = 1'b0;
      finish_run();
   end
endmodule